// File: doc/BRIEF.md
# Multi-Class Interrupt Pending Unit

This block gathers interrupt requests for a small multi-core cluster and holds them as pending state, with one pending vector per core. Three classes share one identifier space. Software-raised interrupts (identifiers 0 to 15) are injected per target core through a command write. Per-core private lines (identifiers 16 to 31) are banked, so the same identifier on two cores names two separate interrupts. Shared lines (identifiers 32 and up) come from wired inputs or from a set command. Each shared line is steered either to one named core or to whichever enabled core has the lowest number.

Every wired input passes through a two-flop synchronizer. Edge detection compares the synchronized value with its value one cycle earlier. An edge-configured source latches a sticky pending bit that only a clear command removes. A level-configured source shows pending for as long as it is held at its active polarity. Private lines are active-low and level-sensitive after reset. Shared lines are active-high and level-sensitive after reset, and can be switched to rising-edge capture. Commands are one write per cycle: an opcode, a core selector, a word index and a 32-bit data word.

Top module: `irq_pend_unit`

## Requirements
- R1: Core c's pending vector occupies `pend_o[c*TOTAL +: TOTAL]`, where TOTAL = 32 + NUM_SHARED. Bits 0..15 are software identifiers, bits 16..31 are that core's private identifiers, and bit 32+k is shared line k. After reset every pending bit is 0.
- R2: Opcode 1 (raise software) sets software identifier `wr_data_i[3:0]` in every core c whose mask bit `wr_data_i[8+c]` is 1. Cores whose mask bit is 0 are left untouched.
- R3: After reset a private line is level-sensitive and active-low. Its pending bit is 1 while `priv_irq_i[c*16+i]` is 0 and returns to 0 when the line goes high. It appears only in core c's vector.
- R4: Opcode 2 writes the trigger bits of private bank `wr_core_i` from `wr_data_i[15:0]` (1 = edge). An edge-mode private line latches pending on a high-to-low transition, and the bit stays set after the line returns high. The other core's bank is unaffected.
- R5: Shared lines are active-high and level-sensitive after reset. Opcode 3 writes the trigger bits of shared word `wr_idx_i` from `wr_data_i` (1 = rising edge). An edge-mode shared line latches pending on a rising edge.
- R6: Opcode 4 sets the sticky pending bit of every shared line k in word `wr_idx_i` whose data bit `wr_data_i[k%32]` is 1.
- R7: Opcode 5 routes shared line `wr_data_i[15:0]`. It uses any-core mode when `wr_data_i[16]` is 1; otherwise it targets core `wr_data_i[24 +: CW]`. After reset every shared line targets core 0. A shared line is delivered to at most one core.
- R8: Opcode 6 loads the core enable mask from `wr_data_i[NUM_CORES-1:0]`; the mask resets to all ones. An any-core line is delivered to the lowest-numbered enabled core. With no core enabled it stays pending, is delivered nowhere, and reappears once a core is enabled.
- R9: Opcode 7 clears the sticky pending bit of identifier `wr_data_i[15:0]`. For software and private identifiers it acts on bank `wr_core_i`; for shared identifiers it acts on the line itself.
- R10: A change on a wired input is not visible on `pend_o` one clock edge after it is driven. A level-mode line becomes visible after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_irq_i | input | NUM_CORES*16 | Private lines, core c at bits c*16+i (identifier 16+i) |
| shared_irq_i | input | NUM_SHARED | Shared lines, bit k is identifier 32+k |
| wr_en_i | input | 1 | Command strobe |
| wr_op_i | input | 3 | Command opcode |
| wr_core_i | input | CW | Bank selector for private config and clear |
| wr_idx_i | input | IW | 32-bit word index for shared config and set |
| wr_data_i | input | 32 | Command data |
| pend_o | output | NUM_CORES*(32+NUM_SHARED) | Per-core pending vectors |

## Verification
On every cycle, the assertions check several properties. A detected edge on an edge-mode line must show as pending on the next cycle. An edge-latched bit must persist until its clear arrives. A raise-software command must reach every core in its mask. No shared line may appear in more than one core, and nothing routed to any core may be delivered while the enable mask is empty. Only the bench scenarios can show the rest: bank separation between cores, the reset polarities, the two-edge synchronizer latency, route moves as the enable mask changes, and clears reaching the right bank.

// File: rtl/irqp_pkg.sv
// Shared opcodes and identifier layout for the interrupt pending unit.
package irqp_pkg;
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_SOFT_GEN = 3'd1,
        OP_PRIV_CFG = 3'd2,
        OP_SHR_CFG  = 3'd3,
        OP_SHR_SET  = 3'd4,
        OP_ROUTE    = 3'd5,
        OP_CORE_EN  = 3'd6,
        OP_CLEAR    = 3'd7
    } wr_op_e;

    localparam int SOFT_N      = 16;
    localparam int PRIV_N      = 16;
    localparam int SHARED_BASE = 32;
endpackage

// File: rtl/irqp_sync.sv
// Two-flop synchronizer plus a one-cycle history stage.
// Assumes inputs are asynchronous. RST_VAL is the idle level, so that
// release from reset cannot produce a spurious edge.
module irqp_sync #(
    parameter int         W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    // Shift the raw lines through metastability, sync and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/irqp_detect.sv
// Per-bit edge or level pending detector.
// Assumes synchronized inputs. The active polarity is fixed by ACTIVE_LOW.
// The sticky bit is set by a detected edge (in edge mode) or by set_i.
// Only clr_i clears it, and a set in the same cycle wins over the clear.
module irqp_detect #(
    parameter int   W          = 8,
    parameter logic ACTIVE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] edge_cfg_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] act, act_prev, hit, sticky_q;

    // Normalize to active-high and find transitions into the active level.
    always_comb begin
        act      = sync_i ^ {W{ACTIVE_LOW}};
        act_prev = prev_i ^ {W{ACTIVE_LOW}};
        hit      = act & ~act_prev & edge_cfg_i;
    end

    // Sticky pending: clear first, then new sets take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~clr_i) | hit | set_i;
    end

    // Level-mode sources show pending while active; edge state always shows.
    assign pend_o = sticky_q | (act & ~edge_cfg_i);

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R4 and R5: an edge into the active level is pending on the next cycle.
        a_r4_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_cfg_i[i] && act[i] && !act_prev[i]) |=> pend_o[i]);
        // R9: an edge-latched bit stays until it is cleared.
        a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && edge_cfg_i[i] && !clr_i[i]) |=> pend_o[i]);
    end
endmodule

// File: rtl/irqp_route.sv
// Steers shared pending bits to cores.
// A line goes either to a fixed target or, in any-core mode, to the
// lowest-numbered enabled core. Targets beyond NC are never delivered.
module irqp_route #(
    parameter int NC = 2,
    parameter int NS = 32,
    parameter int CW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NS-1:0]  shr_pend_i,
    input  logic [NS-1:0]  any_i,
    input  logic [NS*CW-1:0] tgt_i,
    input  logic [NC-1:0]  en_i,
    output logic [NC*NS-1:0] dlv_o
);
    logic [CW-1:0] lowest;
    logic          has_en;

    // Find the lowest-numbered enabled core.
    always_comb begin
        lowest = '0;
        has_en = 1'b0;
        for (int c = NC - 1; c >= 0; c--) begin
            if (en_i[c]) begin
                lowest = CW'(c);
                has_en = 1'b1;
            end
        end
    end

    // Deliver each pending shared line to its chosen core.
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            for (int s = 0; s < NS; s++) begin
                dlv_o[c*NS+s] = shr_pend_i[s] &
                    (any_i[s] ? (has_en && lowest == CW'(c))
                              : (tgt_i[s*CW +: CW] == CW'(c)));
            end
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_chk
        logic [NC-1:0] col;
        // Gather one shared line's delivery across all cores.
        always_comb begin
            for (int c = 0; c < NC; c++) col[c] = dlv_o[c*NS+s];
        end
        a_r7_one_core: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
        a_r8_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i == '0 && any_i[s]) |-> (col == '0));
    end
endmodule

// File: rtl/irq_pend_unit.sv
// Multi-class interrupt pending unit, top level.
// Holds the command-written configuration and the software pending bits.
// Wired lines run through sync, detection and routing instances.
// Assumes one command per cycle and NUM_CORES <= 8.
module irq_pend_unit
    import irqp_pkg::*;
#(
    parameter int NUM_CORES  = 2,
    parameter int NUM_SHARED = 32,
    localparam int CW     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int NWORDS = (NUM_SHARED + 31) / 32,
    localparam int IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int TOTAL  = SHARED_BASE + NUM_SHARED
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CORES*PRIV_N-1:0] priv_irq_i,
    input  logic [NUM_SHARED-1:0]      shared_irq_i,
    input  logic                       wr_en_i,
    input  logic [2:0]                 wr_op_i,
    input  logic [CW-1:0]              wr_core_i,
    input  logic [IW-1:0]              wr_idx_i,
    input  logic [31:0]                wr_data_i,
    output logic [NUM_CORES*TOTAL-1:0] pend_o
);
    localparam int PW = NUM_CORES * PRIV_N;

    wr_op_e op;
    logic   do_soft, do_pcfg, do_scfg, do_sset, do_route, do_en, do_clr;
    logic [15:0] cmd_id;

    logic [NUM_CORES-1:0][SOFT_N-1:0] soft_q;
    logic [PW-1:0]           priv_edge_q, priv_clr, priv_sync, priv_prev, priv_pend;
    logic [NUM_SHARED-1:0]   shr_edge_q, shr_set, shr_clr, shr_sync, shr_prev, shr_pend;
    logic [NUM_SHARED-1:0]   route_any_q;
    logic [NUM_SHARED*CW-1:0] route_tgt_q;
    logic [NUM_CORES-1:0]    core_en_q;
    logic [NUM_CORES*NUM_SHARED-1:0] shr_dlv;

    // Decode the command strobe into per-opcode enables.
    always_comb begin
        op       = wr_op_e'(wr_op_i);
        cmd_id   = wr_data_i[15:0];
        do_soft  = wr_en_i && op == OP_SOFT_GEN;
        do_pcfg  = wr_en_i && op == OP_PRIV_CFG;
        do_scfg  = wr_en_i && op == OP_SHR_CFG;
        do_sset  = wr_en_i && op == OP_SHR_SET;
        do_route = wr_en_i && op == OP_ROUTE;
        do_en    = wr_en_i && op == OP_CORE_EN;
        do_clr   = wr_en_i && op == OP_CLEAR;
    end

    // Software pending bits: clear by identifier, then raise by target mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= '0;
        end else begin
            for (int c = 0; c < NUM_CORES; c++) begin
                if (do_clr && wr_core_i == CW'(c) && cmd_id < 16'(SOFT_N))
                    soft_q[c][cmd_id[3:0]] <= 1'b0;
                if (do_soft && wr_data_i[8+c])
                    soft_q[c][wr_data_i[3:0]] <= 1'b1;
            end
        end
    end

    // Configuration registers: private trigger banks, shared triggers, routes, enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_edge_q <= '0;
            shr_edge_q  <= '0;
            route_any_q <= '0;
            route_tgt_q <= '0;
            core_en_q   <= '1;
        end else begin
            for (int c = 0; c < NUM_CORES; c++)
                if (do_pcfg && wr_core_i == CW'(c))
                    priv_edge_q[c*PRIV_N +: PRIV_N] <= wr_data_i[PRIV_N-1:0];
            for (int s = 0; s < NUM_SHARED; s++) begin
                if (do_scfg && wr_idx_i == IW'(s / 32))
                    shr_edge_q[s] <= wr_data_i[s % 32];
                if (do_route && cmd_id == 16'(s)) begin
                    route_any_q[s]            <= wr_data_i[16];
                    route_tgt_q[s*CW +: CW]   <= wr_data_i[24 +: CW];
                end
            end
            if (do_en) core_en_q <= wr_data_i[NUM_CORES-1:0];
        end
    end

    // Per-bit set and clear strobes for the wired-source detectors.
    always_comb begin
        for (int c = 0; c < NUM_CORES; c++)
            for (int i = 0; i < PRIV_N; i++)
                priv_clr[c*PRIV_N+i] = do_clr && wr_core_i == CW'(c) &&
                                       cmd_id == 16'(SOFT_N + i);
        for (int s = 0; s < NUM_SHARED; s++) begin
            shr_set[s] = do_sset && wr_idx_i == IW'(s / 32) && wr_data_i[s % 32];
            shr_clr[s] = do_clr && cmd_id == 16'(SHARED_BASE + s);
        end
    end

    irqp_sync #(.W(PW), .RST_VAL({PW{1'b1}})) u_priv_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(priv_irq_i),
        .sync_o(priv_sync), .prev_o(priv_prev));

    irqp_detect #(.W(PW), .ACTIVE_LOW(1'b1)) u_priv_det (
        .clk(clk), .rst_n(rst_n), .sync_i(priv_sync), .prev_i(priv_prev),
        .edge_cfg_i(priv_edge_q), .set_i({PW{1'b0}}), .clr_i(priv_clr),
        .pend_o(priv_pend));

    irqp_sync #(.W(NUM_SHARED), .RST_VAL({NUM_SHARED{1'b0}})) u_shr_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(shared_irq_i),
        .sync_o(shr_sync), .prev_o(shr_prev));

    irqp_detect #(.W(NUM_SHARED), .ACTIVE_LOW(1'b0)) u_shr_det (
        .clk(clk), .rst_n(rst_n), .sync_i(shr_sync), .prev_i(shr_prev),
        .edge_cfg_i(shr_edge_q), .set_i(shr_set), .clr_i(shr_clr),
        .pend_o(shr_pend));

    irqp_route #(.NC(NUM_CORES), .NS(NUM_SHARED), .CW(CW)) u_route (
        .clk(clk), .rst_n(rst_n), .shr_pend_i(shr_pend), .any_i(route_any_q),
        .tgt_i(route_tgt_q), .en_i(core_en_q), .dlv_o(shr_dlv));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        // Assemble one core's vector: shared above private above software.
        assign pend_o[c*TOTAL +: TOTAL] = {shr_dlv[c*NUM_SHARED +: NUM_SHARED],
                                           priv_pend[c*PRIV_N +: PRIV_N],
                                           soft_q[c]};

        // R2: a raise-software command reaches every core named in its mask.
        a_r2_soft_reaches: assert property (@(posedge clk) disable iff (!rst_n)
            (do_soft && wr_data_i[8+c]) |=> pend_o[c*TOTAL + 32'($past(wr_data_i[3:0]))]);
    end
endmodule

// File: tb/irq_pend_unit_bench.sv
module irq_pend_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;
    localparam int NS = 32;
    localparam int TOTAL = 32 + NS;

    typedef struct {
        int              core;
        logic [TOTAL-1:0] exp;
        string           tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC*16-1:0] priv_irq = '1;
    logic [NS-1:0]    shared_irq = '0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_op = '0;
    logic [0:0]       wr_core = '0;
    logic [0:0]       wr_idx = '0;
    logic [31:0]      wr_data = '0;
    logic [NC*TOTAL-1:0] pend;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [TOTAL-1:0] e0 = '0, e1 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pend_unit #(.NUM_CORES(NC), .NUM_SHARED(NS)) u_irq_pend_unit (
        .clk(clk), .rst_n(rst_n), .priv_irq_i(priv_irq), .shared_irq_i(shared_irq),
        .wr_en_i(wr_en), .wr_op_i(wr_op), .wr_core_i(wr_core), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .pend_o(pend));

    // Monitor: pop one expected vector per negedge and compare.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [TOTAL-1:0] act;
            it  = q.pop_front();
            act = pend[it.core*TOTAL +: TOTAL];
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s core%0d: actual=%h expected=%h", it.tag, it.core, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] op, input int core, input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_op = op; wr_core = 1'(core); wr_idx = 1'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_op = '0; wr_data = '0;
    endtask

    // Driver side of the scoreboard: wait n edges, then queue both cores.
    task automatic expect_both(input int n, input string tag);
        repeat (n) @(posedge clk);
        #1;
        q.push_back('{core: 0, exp: e0, tag: tag});
        @(posedge clk); #1;
        q.push_back('{core: 1, exp: e1, tag: tag});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: all pending bits clear after reset
        expect_both(2, "R1 reset");

        // R2: software id 5 to core1 only, then id 15 to both
        wr(3'd1, 0, 0, 32'd5 | (32'd1 << 9));
        e1[5] = 1'b1;
        expect_both(1, "R2 soft core1 only");
        wr(3'd1, 1, 0, 32'd15 | (32'd3 << 8));
        e0[15] = 1'b1; e1[15] = 1'b1;
        expect_both(1, "R2 soft both");

        // R10: private level input, not visible after one edge
        @(negedge clk) priv_irq[3] = 1'b0;
        @(posedge clk); #1;
        q.push_back('{core: 0, exp: e0, tag: "R10 one edge"});
        // R3: visible after second edge on core0 only (id 19)
        e0[19] = 1'b1;
        expect_both(1, "R3 private level low");
        @(negedge clk) priv_irq[3] = 1'b1;
        e0[19] = 1'b0;
        expect_both(3, "R3 private released");

        // R4: core1 bank id 18 to edge mode, pulse low
        wr(3'd2, 1, 0, 32'h4);
        @(negedge clk) priv_irq[16+2] = 1'b0;
        repeat (3) @(negedge clk);
        priv_irq[16+2] = 1'b1;
        e1[18] = 1'b1;
        expect_both(4, "R4 private edge sticky");
        // R9: clear id 18 in bank1
        wr(3'd7, 1, 0, 32'd18);
        e1[18] = 1'b0;
        expect_both(1, "R9 clear private");

        // R5: shared 4 level, routed to core0 by default (R7)
        @(negedge clk) shared_irq[4] = 1'b1;
        e0[36] = 1'b1;
        expect_both(3, "R5 shared level");
        @(negedge clk) shared_irq[4] = 1'b0;
        e0[36] = 1'b0;
        expect_both(3, "R5 shared released");
        // R5: shared 7 rising edge mode
        wr(3'd3, 0, 0, 32'h80);
        @(negedge clk) shared_irq[7] = 1'b1;
        repeat (3) @(negedge clk);
        shared_irq[7] = 1'b0;
        e0[39] = 1'b1;
        expect_both(4, "R5 shared edge sticky");

        // R7: route shared 7 to core1
        wr(3'd5, 0, 0, 32'd7 | (32'd1 << 24));
        e0[39] = 1'b0; e1[39] = 1'b1;
        expect_both(1, "R7 route to core1");

        // R6: set shared 10 by command
        wr(3'd4, 0, 0, 32'd1 << 10);
        e0[42] = 1'b1;
        expect_both(1, "R6 shared set");

        // R8: shared 10 any-core, mask all ones -> core0
        wr(3'd5, 0, 0, 32'd10 | (32'd1 << 16));
        expect_both(1, "R8 any lowest");
        wr(3'd6, 0, 0, 32'h2);
        e0[42] = 1'b0; e1[42] = 1'b1;
        expect_both(1, "R8 any core1 only enabled");
        wr(3'd6, 0, 0, 32'h0);
        e1[42] = 1'b0;
        expect_both(1, "R8 none enabled");
        wr(3'd6, 0, 0, 32'h1);
        e0[42] = 1'b1;
        expect_both(1, "R8 re-enabled");

        // R9: clear shared 10 and software bits per bank
        wr(3'd7, 1, 0, 32'd42);
        e0[42] = 1'b0;
        expect_both(1, "R9 clear shared");
        wr(3'd7, 1, 0, 32'd5);
        e1[5] = 1'b0;
        expect_both(1, "R9 clear soft bank1");
        wr(3'd7, 0, 0, 32'd15);
        e0[15] = 1'b0;
        expect_both(1, "R9 clear soft bank0 only");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule